// File: doc/BRIEF.md
# FIR Cell Coefficient and Sample Loader

This block is the front end of one tap cell in a cascadable FIR filter. It holds the two operands of the cell's multiplier: a signed coefficient word and a signed sample word. Each operand has its own active-low load request. A load request is registered inside the block, so a capture takes place one clock after the request is seen. The host therefore drives the request low one cycle before it presents the word.

Coefficients also pass along to the next cell in the cascade. On their way they go through a run-time selectable chain of zero to three decimation delay stages. The tap chosen by the 2-bit mode select drives a coefficient output that floats when its output-enable is low. The coefficient register and the decimation stages keep their contents while no load is active. The sample register fills with zeros when no load is active.

Each load request goes through a two-state arming machine. `ARM_IDLE` means no capture on the coming edge, and `ARM_LIVE` means a capture on the coming edge. The transition `IDLE->LIVE` is taken when the request is low at an edge. `LIVE->IDLE` is taken when it is high. `IDLE->IDLE` and `LIVE->LIVE` hold while the request keeps its level. Reset forces `ARM_IDLE`.

Top module: `fir_cell_loader`

## Requirements
- R1: A synchronous active-high reset clears the coefficient register, all decimation stages and the sample register to zero and puts both arming machines in `ARM_IDLE`. The first edge after reset therefore captures nothing, even if a load request was low during reset.
- R2: When `coef_ld_n` is low at clock edge k, `coef_q` takes the value of `coef_in` present at edge k+1. Edge k itself captures nothing. The same one-edge lag applies when the request is released.
- R3: On an edge where no coefficient capture is armed, `coef_q` and every decimation stage keep their values.
- R4: Mode encoding on `dec_mode`: 0 selects the coefficient register, and 1, 2 and 3 select the output of the first, second and third decimation stage. The chain advances one stage on each coefficient capture edge. After loads of V0, V1, V2, V3 the modes 0..3 show V3, V2, V1, V0.
- R5: With `coef_oe` high and mode 0, `coef_out` equals `coef_q` in the same cycle, with no added register.
- R6: When `samp_ld_n` is low at edge k, `samp_q` takes the value of `samp_in` present at edge k+1.
- R7: On an edge where no sample capture is armed, `samp_q` becomes all zeros.
- R8: When `coef_oe` is low, `coef_out` is released (high impedance) and does not carry the selected coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coef_in | input | 9 | Coefficient word to capture |
| coef_ld_n | input | 1 | Coefficient load request, active low, acts one edge later |
| coef_oe | input | 1 | Output-enable for `coef_out`, active high |
| dec_mode | input | 2 | Decimation tap select, 0 to 3 extra stages |
| coef_out | output | 9 | Coefficient passed to the next cell, tri-stated |
| coef_q | output | 9 | Coefficient register, multiplier operand |
| samp_in | input | 9 | Sample word to capture |
| samp_ld_n | input | 1 | Sample load request, active low, acts one edge later |
| samp_q | output | 9 | Sample register, multiplier operand |

## Verification
An arming machine stuck in the wrong state shows at `coef_q` or `samp_q` one edge after the request changes. The symptom is a capture that is one cycle early or late, or a missing capture. Fault on the sample side also shows as a zero that should not be there. A decimation stage that shifts on idle edges, or a tap mux that picks the wrong stage, shows only on `coef_out`. It shows on the first edge where the chain should hold, or as soon as the mode is switched after a four-word load. A reset that leaves any stage or arming state dirty shows on the first edge after release.

// File: rtl/fir_ld_pkg.sv
package fir_ld_pkg;

    // States of a load-request arming machine
    typedef enum logic {
        ARM_IDLE = 1'b0,   // no capture on the coming edge
        ARM_LIVE = 1'b1    // capture on the coming edge
    } arm_state_e;

    // Width of a mode select able to address taps 0..max_dec
    function automatic int mode_width(input int max_dec);
        int w;
        w = 1;
        while ((1 << w) < (max_dec + 1)) w++;
        return w;
    endfunction

endpackage

// File: rtl/fir_ld_arm.sv
module fir_ld_arm
    import fir_ld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    output logic go
);

    arm_state_e state_q;
    arm_state_e state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ARM_IDLE;
        else     state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ARM_IDLE: state_nx = req_n ? ARM_IDLE : ARM_LIVE;
            ARM_LIVE: state_nx = req_n ? ARM_IDLE : ARM_LIVE;
            default:  state_nx = ARM_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ARM_LIVE: go = 1'b1;
            default:  go = 1'b0;
        endcase
    end

endmodule

// File: rtl/fir_samp_reg.sv
module fir_samp_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Zero-fill when not armed, no hold
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (go) q <= d;
        else         q <= '0;
    end

endmodule

// File: rtl/fir_coef_path.sv
module fir_coef_path #(
    parameter  int W       = 9,
    parameter  int MAX_DEC = 3,
    localparam int MW      = fir_ld_pkg::mode_width(MAX_DEC),
    localparam int NTAP    = 1 << MW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [W-1:0]  d,
    input  logic [MW-1:0] mode,
    output logic [W-1:0]  creg,
    output logic [W-1:0]  tap
);

    logic [W-1:0] taps [NTAP];

    // Coefficient register: holds when not armed
    always_ff @(posedge clk) begin
        if (rst)     creg <= '0;
        else if (go) creg <= d;
    end

    assign taps[0] = creg;

    // Decimation stages, each advancing only on a capture edge
    for (genvar i = 0; i < MAX_DEC; i++) begin : g_stage
        logic [W-1:0] stage_q;
        always_ff @(posedge clk) begin
            if (rst)     stage_q <= '0;
            else if (go) stage_q <= taps[i];
        end
        assign taps[i+1] = stage_q;
    end

    // Unused mode codes repeat the deepest stage
    for (genvar j = MAX_DEC + 1; j < NTAP; j++) begin : g_fill
        assign taps[j] = taps[MAX_DEC];
    end

    assign tap = taps[mode];

endmodule

// File: rtl/fir_cell_loader.sv
module fir_cell_loader #(
    parameter  int W       = 9,
    parameter  int MAX_DEC = 3,
    localparam int MW      = fir_ld_pkg::mode_width(MAX_DEC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  coef_in,
    input  logic          coef_ld_n,
    input  logic          coef_oe,
    input  logic [MW-1:0] dec_mode,
    output logic [W-1:0]  coef_out,
    output logic [W-1:0]  coef_q,
    input  logic [W-1:0]  samp_in,
    input  logic          samp_ld_n,
    output logic [W-1:0]  samp_q
);

    logic         coef_go;
    logic         samp_go;
    logic [W-1:0] coef_tap;

    fir_ld_arm u_coef_arm (
        .clk   (clk),
        .rst   (rst),
        .req_n (coef_ld_n),
        .go    (coef_go)
    );

    fir_ld_arm u_samp_arm (
        .clk   (clk),
        .rst   (rst),
        .req_n (samp_ld_n),
        .go    (samp_go)
    );

    fir_coef_path #(.W(W), .MAX_DEC(MAX_DEC)) u_coef (
        .clk  (clk),
        .rst  (rst),
        .go   (coef_go),
        .d    (coef_in),
        .mode (dec_mode),
        .creg (coef_q),
        .tap  (coef_tap)
    );

    fir_samp_reg #(.W(W)) u_samp (
        .clk (clk),
        .rst (rst),
        .go  (samp_go),
        .d   (samp_in),
        .q   (samp_q)
    );

    assign coef_out = coef_oe ? coef_tap : {W{1'bz}};

endmodule

// File: rtl/fir_cell_loader_chk.sv
module fir_cell_loader_chk #(
    parameter int W  = 9,
    parameter int MW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  coef_in,
    input logic          coef_ld_n,
    input logic          coef_oe,
    input logic [MW-1:0] dec_mode,
    input logic [W-1:0]  coef_out,
    input logic [W-1:0]  coef_q,
    input logic [W-1:0]  samp_in,
    input logic          samp_ld_n,
    input logic [W-1:0]  samp_q
);

    a_r2_coef_capture_lag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(coef_ld_n, 2))
            |-> (coef_q == $past(coef_in)));

    a_r3_coef_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(coef_ld_n, 2)) |-> $stable(coef_q));

    a_r4_first_stage_shift: assert property (@(posedge clk) disable iff (rst)
        (coef_oe && dec_mode == MW'(1) && !$past(rst) && !$past(rst, 2)
         && !$past(coef_ld_n, 2))
            |-> (coef_out == $past(coef_q)));

    a_r5_bypass_tap: assert property (@(posedge clk) disable iff (rst)
        (coef_oe && dec_mode == MW'(0)) |-> (coef_out == coef_q));

    a_r6_samp_capture_lag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(samp_ld_n, 2))
            |-> (samp_q == $past(samp_in)));

    a_r7_samp_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(samp_ld_n, 2)) |-> (samp_q == '0));

endmodule

bind fir_cell_loader fir_cell_loader_chk #(.W(W), .MW(MW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .coef_in   (coef_in),
    .coef_ld_n (coef_ld_n),
    .coef_oe   (coef_oe),
    .dec_mode  (dec_mode),
    .coef_out  (coef_out),
    .coef_q    (coef_q),
    .samp_in   (samp_in),
    .samp_ld_n (samp_ld_n),
    .samp_q    (samp_q)
);

// File: tb/sim_fir_cell_loader.sv
`timescale 1ns/1ps
module sim_fir_cell_loader;

    logic       clk = 1'b0;
    logic       rst;
    logic [8:0] coef_in;
    logic       coef_ld_n;
    logic       coef_oe;
    logic [1:0] dec_mode;
    logic [8:0] coef_out;
    logic [8:0] coef_q;
    logic [8:0] samp_in;
    logic       samp_ld_n;
    logic [8:0] samp_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fir_cell_loader u0 (
        .clk       (clk),
        .rst       (rst),
        .coef_in   (coef_in),
        .coef_ld_n (coef_ld_n),
        .coef_oe   (coef_oe),
        .dec_mode  (dec_mode),
        .coef_out  (coef_out),
        .coef_q    (coef_q),
        .samp_in   (samp_in),
        .samp_ld_n (samp_ld_n),
        .samp_q    (samp_q)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; coef_ld_n = 1'b1; samp_ld_n = 1'b1;
        coef_in = '0; samp_in = '0; coef_oe = 1'b1; dec_mode = 2'd0;
        tick(); tick();
        rst = 1'b0;
    endtask

    // R1: cleared state, arming machines idle after reset
    task automatic t_reset();
        rst = 1'b1; coef_oe = 1'b1; dec_mode = 2'd0;
        coef_ld_n = 1'b0; samp_ld_n = 1'b0;
        coef_in = 9'h1AA; samp_in = 9'h0CC;
        tick(); tick();
        check("R1 coef_q after reset", coef_q, 9'h000);
        check("R1 samp_q after reset", samp_q, 9'h000);
        for (int m = 0; m < 4; m++) begin
            dec_mode = 2'(m); #0.1;
            check("R1 stage cleared", coef_out, 9'h000);
        end
        dec_mode = 2'd0;
        rst = 1'b0;
        tick();
        check("R1 first edge captures nothing (coef)", coef_q, 9'h000);
        check("R1 first edge captures nothing (samp)", samp_q, 9'h000);
        coef_ld_n = 1'b1; samp_ld_n = 1'b1;
    endtask

    // R2, R3, R5
    task automatic t_coef_load();
        do_reset();
        coef_ld_n = 1'b0; coef_in = 9'h0AA;
        tick();
        check("R2 no capture on request edge", coef_q, 9'h000);
        coef_in = 9'h155;
        tick();
        check("R2 capture one edge later", coef_q, 9'h155);
        check("R5 mode 0 follows coef_q", coef_out, 9'h155);
        coef_ld_n = 1'b1; coef_in = 9'h0F0;
        tick();
        check("R2 release lags one edge", coef_q, 9'h0F0);
        coef_in = 9'h1FF;
        tick();
        check("R3 hold when idle", coef_q, 9'h0F0);
        coef_in = 9'h003;
        tick();
        check("R3 hold second idle edge", coef_q, 9'h0F0);
    endtask

    // R4, R3 on the chain
    task automatic t_chain();
        logic [8:0] v [4];
        v[0] = 9'h011; v[1] = 9'h122; v[2] = 9'h033; v[3] = 9'h144;
        do_reset();
        coef_ld_n = 1'b0;
        tick();
        for (int i = 0; i < 4; i++) begin
            coef_in = v[i];
            if (i == 3) coef_ld_n = 1'b1;
            tick();
        end
        for (int m = 0; m < 4; m++) begin
            dec_mode = 2'(m); #0.1;
            check("R4 tap after four loads", coef_out, v[3-m]);
        end
        coef_in = 9'h1EE;
        tick();
        for (int m = 0; m < 4; m++) begin
            dec_mode = 2'(m); #0.1;
            check("R3 chain holds when idle", coef_out, v[3-m]);
        end
        dec_mode = 2'd0;
    endtask

    // R6, R7
    task automatic t_sample();
        do_reset();
        samp_ld_n = 1'b0; samp_in = 9'h123;
        tick();
        check("R6 no capture on request edge", samp_q, 9'h000);
        samp_in = 9'h1C3;
        tick();
        check("R6 capture one edge later", samp_q, 9'h1C3);
        samp_ld_n = 1'b1; samp_in = 9'h0AB;
        tick();
        check("R6 release lags one edge", samp_q, 9'h0AB);
        samp_in = 9'h1FF;
        tick();
        check("R7 zero fill when idle", samp_q, 9'h000);
    endtask

    // R8
    task automatic t_output_enable();
        do_reset();
        coef_ld_n = 1'b0;
        tick();
        coef_in = 9'h1B7; coef_ld_n = 1'b1;
        tick();
        coef_oe = 1'b0; #0.1;
        n_chk++;
        if (coef_out === 9'h1B7) begin
            n_fail++;
            $display("FAIL R8 released output: actual %h expected not %h", coef_out, 9'h1B7);
        end
        coef_oe = 1'b1; #0.1;
        check("R8 driven again when enabled", coef_out, 9'h1B7);
    endtask

    initial begin
        t_reset();
        t_coef_load();
        t_chain();
        t_sample();
        t_output_enable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule